// File: doc/BRIEF.md
# Piecewise-linear energy decoder

This block expands a 12-bit compressed energy code into a signed linear energy value. Before anything else, the incoming word is cut down to its low 12 bits. The block then applies two clamp rules. A code of zero is treated as the code that decodes to zero energy. A small non-zero code is raised to a fixed floor.

The clamped code is compared against a fixed ladder of six thresholds. The comparisons form a thermometer vector, and the exact pattern of that vector picks one of four linear segments. Each segment is a left shift of the code (by 0, 1, 2 or 10 places) minus a segment-specific offset. Codes above the top rung saturate to the largest positive output.

Each result is registered once. A valid flag travels alongside it with the same one-cycle delay. The consumer is a tower accumulator that takes one decoded value per valid cycle.

Top module: `pwl_energy_decoder`

## Requirements
- R1: Only bits [11:0] of `in_code` affect the result; bits [15:12] are ignored.
- R2: A masked code of 0 is decoded as if it were 1262, giving an output of 0.
- R3: A masked code from 1 to 961 is decoded as if it were 962, giving an output of -300. No valid output is ever below -300.
- R4: A clamped code c with 749 < c <= 1773 gives c - 1262. The comparison vector (bit i set when c is strictly greater than threshold i, thresholds 5, 749, 1773, 2541, 4029, 4062) is always a run of ones from bit 0.
- R5: A clamped code c with 1773 < c <= 2541 gives 2c - 3036.
- R6: A clamped code c with 2541 < c <= 4029 gives 4c - 8120.
- R7: A clamped code c with 4029 < c <= 4062 gives 1024c - 4118720.
- R8: A clamped code above 4062 gives the maximum positive value, 8388607.
- R9: `out_valid` equals `in_valid` from one cycle earlier. `out_energy` takes the decoded value one clock after a valid input and holds its value in any cycle that follows an invalid input.
- R10: During reset, and until the first valid input has been registered, `out_valid` is 0 and `out_energy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Input code is valid this cycle |
| in_code | input | 16 | Raw compressed code; only bits [11:0] are used |
| out_valid | output | 1 | Registered copy of `in_valid` |
| out_energy | output | 24 | Signed decoded linear energy |

## Verification
Directed vectors are placed on both sides of every threshold (for example 1773/1774, 2541/2542, 4029/4030, 4062/4063). They also cover 0, 1, 961, 962 and 4095. These vectors separate an off-by-one in a comparison from a wrong slope or offset, and a zero clamp from a floor clamp. Random 16-bit codes with junk in the upper nibble check the masking. Further random codes, drawn inside each segment's range, check the slopes and offsets away from the edges. Idle cycles with changing input check that the output holds its value and that the valid flag keeps its one-cycle delay.

// File: rtl/pwl_pkg.sv
package pwl_pkg;
  localparam int CODE_W   = 12;
  localparam int N_TH     = 6;
  localparam int N_SEG    = 4;
  localparam int ZERO_SUB = 1262;
  localparam int FLOOR    = 962;
  localparam int unsigned TH    [N_TH]  = '{5, 749, 1773, 2541, 4029, 4062};
  localparam int unsigned SHIFT [N_SEG] = '{0, 1, 2, 10};
  localparam int unsigned OFFS  [N_SEG] = '{1262, 3036, 8120, 4118720};
  localparam int SEG_W    = CODE_W + 10 + 2;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [N_TH-1:0]   therm_t;
endpackage

// File: rtl/pwl_rst_sync.sv
module pwl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/pwl_code_clamp.sv
module pwl_code_clamp
  import pwl_pkg::*;
#(
  parameter int IN_W = 16
) (
  input  logic [IN_W-1:0] raw,
  output code_t           code
);
  code_t masked;
  logic  unused_hi;

  assign masked    = raw[CODE_W-1:0];
  assign unused_hi = ^raw[IN_W-1:CODE_W];

  always_comb begin
    if (masked == '0)                     code = CODE_W'(ZERO_SUB);
    else if (masked < CODE_W'(FLOOR))     code = CODE_W'(FLOOR);
    else                                  code = masked;
  end
endmodule

// File: rtl/pwl_thermo_ladder.sv
module pwl_thermo_ladder
  import pwl_pkg::*;
(
  input  code_t  code,
  output therm_t therm
);
  for (genvar i = 0; i < N_TH; i++) begin : g_rung
    assign therm[i] = (code > CODE_W'(TH[i]));
  end
endmodule

// File: rtl/pwl_segment_mux.sv
module pwl_segment_mux
  import pwl_pkg::*;
#(
  parameter int OUT_W = 24
) (
  input  code_t                    code,
  input  therm_t                   therm,
  output logic signed [OUT_W-1:0]  energy
);
  localparam logic signed [OUT_W-1:0] SAT = {1'b0, {(OUT_W-1){1'b1}}};

  logic signed [SEG_W-1:0] cand [N_SEG];

  for (genvar k = 0; k < N_SEG; k++) begin : g_seg
    logic [SEG_W-1:0] shifted;
    assign shifted = SEG_W'(code) << SHIFT[k];
    assign cand[k] = $signed(shifted) - $signed(SEG_W'(OFFS[k]));
  end

  always_comb begin
    energy = '0;
    for (int k = 0; k < N_SEG; k++) begin
      if (therm == N_TH'((1 << (k + 2)) - 1)) energy = OUT_W'(cand[k]);
    end
    if (therm == '1) energy = SAT;
  end
endmodule

// File: rtl/pwl_energy_decoder.sv
module pwl_energy_decoder
  import pwl_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int OUT_W = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [IN_W-1:0]         in_code,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_energy
);
  localparam logic signed [OUT_W-1:0] SAT = {1'b0, {(OUT_W-1){1'b1}}};

  logic                    rst_sync_n;
  code_t                   code_c;
  therm_t                  therm_c;
  logic signed [OUT_W-1:0] energy_c;
  logic                    valid_d;
  logic signed [OUT_W-1:0] energy_d;

  pwl_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  pwl_code_clamp #(.IN_W(IN_W)) u_clamp (.raw(in_code), .code(code_c));

  pwl_thermo_ladder u_ladder (.code(code_c), .therm(therm_c));

  pwl_segment_mux #(.OUT_W(OUT_W)) u_mux (
    .code(code_c), .therm(therm_c), .energy(energy_c)
  );

  // next state: clock enable on the data register is in_valid
  always_comb begin
    valid_d  = in_valid;
    energy_d = out_energy;
    if (in_valid) energy_d = energy_c;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid  <= 1'b0;
      out_energy <= '0;
    end else begin
      out_valid  <= valid_d;
      out_energy <= energy_d;
    end
  end

  // ladder must be a run of ones from bit 0
  p_thermo_mono_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |-> ((therm_c & (therm_c + 1'b1)) == '0));

  p_valid_delay_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> (!out_valid && $stable(out_energy)));

  p_saturate_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && (in_code[CODE_W-1:0] > CODE_W'(TH[N_TH-1]))) |=> (out_energy == SAT));

  p_floor_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> (out_energy >= -OUT_W'(300)));
endmodule

// File: tb/pwl_energy_decoder_tb.sv
module pwl_energy_decoder_tb;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic [15:0]        in_code = '0;
  logic               out_valid;
  logic signed [23:0] out_energy;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  pwl_energy_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
    .out_valid(out_valid), .out_energy(out_energy)
  );

  function automatic int model(input int raw);
    int c;
    c = raw & 32'hFFF;
    if (c == 0) c = 1262;
    else if (c < 962) c = 962;
    if (c > 4062) return 8388607;
    if (c > 4029) return c * 1024 - 4118720;
    if (c > 2541) return c * 4 - 8120;
    if (c > 1773) return c * 2 - 3036;
    if (c > 749)  return c - 1262;
    return 0;
  endfunction

  function automatic string tag_of(input int raw);
    int c;
    c = raw & 32'hFFF;
    if (c == 0) return "R2";
    if (c < 962) return "R3";
    if (c > 4062) return "R8";
    if (c > 4029) return "R7";
    if (c > 2541) return "R6";
    if (c > 1773) return "R5";
    return "R4";
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input int raw, input string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_code  = 16'(raw);
    @(negedge clk);
    check(req, int'(out_energy), model(raw));
    check("R9", int'(out_valid), 1);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R10", int'(out_valid), 0);
    check("R10", int'(out_energy), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10", int'(out_valid), 0);
    check("R10", int'(out_energy), 0);

    // directed corners
    apply(0, "R2");
    apply(1, "R3");
    apply(961, "R3");
    apply(962, "R3");
    apply(1262, "R4");
    apply(1773, "R4");
    apply(1774, "R5");
    apply(2541, "R5");
    apply(2542, "R6");
    apply(4029, "R6");
    apply(4030, "R7");
    apply(4062, "R7");
    apply(4063, "R8");
    apply(4095, "R8");
    apply(16'hF000, "R1");     // masks to 0
    apply(16'hA6DD, "R1");     // masks to 1757
    apply(16'h53C3, "R1");     // masks to 963

    // hold while idle: output keeps the last decoded value
    begin
      int last;
      last = model(2000);
      apply(2000, "R5");
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_code  = 16'($urandom);
        @(negedge clk);
        check("R9", int'(out_valid), 0);
        check("R9", int'(out_energy), last);
      end
    end

    // random inside each segment
    for (int i = 0; i < 300; i++) begin
      int lo [5] = '{962, 1774, 2542, 4030, 4063};
      int hi [5] = '{1773, 2541, 4029, 4062, 4095};
      int s;
      int v;
      s = int'($urandom % 5);
      v = lo[s] + int'($urandom % 32'(hi[s] - lo[s] + 1));
      apply(v, tag_of(v));
    end

    // fully random 16-bit codes, back to back
    for (int i = 0; i < 2000; i++) begin
      int v;
      v = int'($urandom & 32'hFFFF);
      if (i % 7 == 0) v = v & 32'hF3FF;
      apply(v, (v > 4095) ? "R1" : tag_of(v));
    end

    // floor bound on a spread of small codes
    for (int v = 1; v < 962; v += 37) begin
      apply(v, "R3");
      check("R3", int'(out_energy >= -300), 1);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule